// File: doc/BRIEF.md
# Banked GPIO Pin-Mux Controller

This block is a register-controlled pad controller for a number of 32-pad banks. Each pad is either a general-purpose I/O, driven by its own direction and output-level bits, or an alternate function, where a peripheral's output and output-enable pass straight to the pad. Each pad also has a bias setting (none, pull-up or pull-down), and its input level is synchronised so that software can read it back.

Software reaches the registers over a simple word-addressed synchronous bus. The bank number sits in the upper address bits and a 3-bit register index sits in the lower three. The registers, by index, are:

- 0: function select
- 1: direction
- 2: output level
- 3: input level, read-only
- 4: bias enable
- 5: bias polarity

Within each register, bit b belongs to pad `bank*32 + b`. A per-bank parameter can leave out the function-select register. Such a bank is a fixed GPIO bank and has no alternate function.

Top module: `gpio_pinmux_top`

## Requirements
- R1: The word at bus address `bank*8 + idx` holds register idx of that bank, and bit b controls pad `bank*32+b`. Register indices are 0 = function select, 1 = direction, 2 = output level, 3 = input level, 4 = bias enable, 5 = bias polarity. Read data is registered, so it appears on `busRdata` one clock after the address.
- R2: After reset, every built function-select register reads all ones. Direction, output level, bias enable and bias polarity are all zero. As a result, `padOe`, `padOut`, `padPullUp` and `padPullDn` are all low.
- R3: A function-select bit of 1 makes the pad a GPIO: `padOe` follows its direction bit and `padOut` follows its output-level bit. A function-select bit of 0 passes `altOe` and `altOut` through to the pad. A register write takes effect on the pad outputs from the clock edge that performs it.
- R4: A GPIO pad with a direction bit of 0 is an input, and its `padOe` is low.
- R5: A bias-enable bit of 0 drives both `padPullUp` and `padPullDn` low. A bias-enable bit of 1 raises `padPullUp` when the polarity bit is 1, and raises `padPullDn` when the polarity bit is 0.
- R6: In a bank built without function select (parameter bit `BANK_HAS_EN[bank]` = 0), every pad is always a GPIO. Index 0 of that bank reads zero and ignores writes.
- R7: The input-level register shows `padIn` through a two-flop synchroniser, whatever the pad's direction. A pad change made before clock edge k is stored at edge k+1 and is read back on the bus at edge k+2.
- R8: Output-level bits written while a pad is an input are kept. Setting the direction bit then drives the stored level from that same edge.
- R9: Writes to index 3 change no register. Reads of index 6 or 7, or of a bank number at or above `NUM_BANKS`, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Word address: bank in the upper bits, register index in bits 2:0 |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| padIn | input | PADS | Pad input levels |
| padOut | output | PADS | Pad output levels |
| padOe | output | PADS | Pad output enables |
| padPullUp | output | PADS | Pull-up control |
| padPullDn | output | PADS | Pull-down control |
| altOut | input | PADS | Alternate-function output levels |
| altOe | input | PADS | Alternate-function output enables |

## Verification
Pad controls depend on the register state only through combinational logic. They are therefore sampled on the falling edge right after the rising edge that performs a write, and compared with the values a bench model of the registers predicts. Read data arrives one edge after the address, so every read presents the address on one falling edge and samples on the next. The input-level register lags the pads by two edges plus the one-edge read. The bench checks this by reading at once, expecting the old level, and then reading again after one extra clock, expecting the new level. In the random phase, the pad inputs always settle for one clock before any read.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int PADS_PER_BANK = 32;
  localparam int IDX_W = 3;
  localparam int BANK_FIELD_W = 8;

  localparam logic [IDX_W-1:0] REG_FSEL = 3'd0;
  localparam logic [IDX_W-1:0] REG_DIR  = 3'd1;
  localparam logic [IDX_W-1:0] REG_DOUT = 3'd2;
  localparam logic [IDX_W-1:0] REG_DIN  = 3'd3;
  localparam logic [IDX_W-1:0] REG_PEN  = 3'd4;
  localparam logic [IDX_W-1:0] REG_PSEL = 3'd5;

  // strobes passed from decode to the register datapath
  typedef struct packed {
    logic                    wrEn;   // write to a writable, mapped register
    logic                    hit;    // address maps to a readable register
    logic [IDX_W-1:0]        regSel;
    logic [BANK_FIELD_W-1:0] bank;
  } regStrobe_t;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strobe
);
  localparam int BANK_BITS = ADDR_W - IDX_W;

  logic [BANK_BITS-1:0] bankIdx;
  logic [IDX_W-1:0]     idx;
  logic                 bankOk;
  logic                 idxOk;

  assign bankIdx = busAddr[ADDR_W-1:IDX_W];
  assign idx     = busAddr[IDX_W-1:0];
  assign bankOk  = 32'(bankIdx) < NUM_BANKS;
  assign idxOk   = idx <= REG_PSEL;

  always_comb begin
    strobe        = '0;
    strobe.regSel = idx;
    strobe.bank   = BANK_FIELD_W'(bankIdx);
    strobe.hit    = bankOk && idxOk;
    strobe.wrEn   = busWr && bankOk && idxOk && (idx != REG_DIN);
  end
endmodule

// File: rtl/pinmux_datapath.sv
module pinmux_datapath
  import pinmux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS-1:0] BANK_HAS_EN = NUM_BANKS'(1),
  localparam int PADS = NUM_BANKS * PADS_PER_BANK
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strobe,
  input  logic [31:0]     busWdata,
  input  logic [PADS-1:0] padIn,
  output logic [31:0]     busRdata,
  output logic [PADS-1:0] gpioSel,
  output logic [PADS-1:0] dirBits,
  output logic [PADS-1:0] doutBits,
  output logic [PADS-1:0] penBits,
  output logic [PADS-1:0] pselBits
);
  logic [31:0] fselR [NUM_BANKS];
  logic [31:0] dirR  [NUM_BANKS];
  logic [31:0] doutR [NUM_BANKS];
  logic [31:0] penR  [NUM_BANKS];
  logic [31:0] pselR [NUM_BANKS];
  logic [PADS-1:0] syncA, syncB;
  logic [31:0] rdNext;

  // register file, one loop over banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        fselR[b] <= BANK_HAS_EN[b] ? 32'hFFFF_FFFF : 32'h0;
        dirR[b]  <= '0;
        doutR[b] <= '0;
        penR[b]  <= '0;
        pselR[b] <= '0;
      end
    end else if (strobe.wrEn) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe.bank == BANK_FIELD_W'(b)) begin
          case (strobe.regSel)
            REG_FSEL: if (BANK_HAS_EN[b]) fselR[b] <= busWdata;
            REG_DIR:  dirR[b]  <= busWdata;
            REG_DOUT: doutR[b] <= busWdata;
            REG_PEN:  penR[b]  <= busWdata;
            REG_PSEL: pselR[b] <= busWdata;
            default: ;
          endcase
        end
      end
    end
  end

  // two-flop input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    if (BANK_HAS_EN[b]) begin : gSel
      assign gpioSel[b*PADS_PER_BANK +: PADS_PER_BANK] = fselR[b];
    end else begin : gFixed
      assign gpioSel[b*PADS_PER_BANK +: PADS_PER_BANK] = '1;
      // R6: missing function select reads as zero
      assert_fixed_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.hit && strobe.regSel == REG_FSEL && strobe.bank == BANK_FIELD_W'(b))
        |=> busRdata == 32'h0);
    end
    assign dirBits[b*PADS_PER_BANK +: PADS_PER_BANK]  = dirR[b];
    assign doutBits[b*PADS_PER_BANK +: PADS_PER_BANK] = doutR[b];
    assign penBits[b*PADS_PER_BANK +: PADS_PER_BANK]  = penR[b];
    assign pselBits[b*PADS_PER_BANK +: PADS_PER_BANK] = pselR[b];

    // R1: a direction write lands in the addressed bank
    assert_dir_write_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.regSel == REG_DIR && strobe.bank == BANK_FIELD_W'(b))
      |=> dirR[b] == $past(busWdata));
    // R9: without a write strobe, stored state stays put
    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrEn |=> ($stable(dirR[b]) && $stable(doutR[b]) && $stable(penR[b])
                        && $stable(pselR[b]) && $stable(fselR[b])));
  end

  // read mux, registered output
  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.hit && strobe.bank == BANK_FIELD_W'(b)) begin
        case (strobe.regSel)
          REG_FSEL: rdNext = BANK_HAS_EN[b] ? fselR[b] : 32'h0;
          REG_DIR:  rdNext = dirR[b];
          REG_DOUT: rdNext = doutR[b];
          REG_DIN:  rdNext = syncB[b*PADS_PER_BANK +: PADS_PER_BANK];
          REG_PEN:  rdNext = penR[b];
          REG_PSEL: rdNext = pselR[b];
          default:  rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hit |=> busRdata == 32'h0);

  // R7: synchroniser lag, counted from reset release
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assert_sync_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> syncB == $past(padIn, 2));
endmodule

// File: rtl/pinmux_padmux.sv
module pinmux_padmux #(
  parameter int PADS = 64
) (
  input  logic [PADS-1:0] gpioSel,
  input  logic [PADS-1:0] dirBits,
  input  logic [PADS-1:0] doutBits,
  input  logic [PADS-1:0] penBits,
  input  logic [PADS-1:0] pselBits,
  input  logic [PADS-1:0] altOut,
  input  logic [PADS-1:0] altOe,
  output logic [PADS-1:0] padOut,
  output logic [PADS-1:0] padOe,
  output logic [PADS-1:0] padPullUp,
  output logic [PADS-1:0] padPullDn
);
  for (genvar p = 0; p < PADS; p++) begin : gPad
    always_comb begin
      if (gpioSel[p]) begin
        padOe[p]  = dirBits[p];
        padOut[p] = doutBits[p];
      end else begin
        padOe[p]  = altOe[p];
        padOut[p] = altOut[p];
      end
      padPullUp[p] = penBits[p] & pselBits[p];
      padPullDn[p] = penBits[p] & ~pselBits[p];
    end
  end
endmodule

// File: rtl/gpio_pinmux_top.sv
module gpio_pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS-1:0] BANK_HAS_EN = NUM_BANKS'(1),
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = BANK_BITS + IDX_W,
  localparam int PADS = NUM_BANKS * PADS_PER_BANK
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [PADS-1:0]   padIn,
  output logic [PADS-1:0]   padOut,
  output logic [PADS-1:0]   padOe,
  output logic [PADS-1:0]   padPullUp,
  output logic [PADS-1:0]   padPullDn,
  input  logic [PADS-1:0]   altOut,
  input  logic [PADS-1:0]   altOe
);
  regStrobe_t strobe;
  logic [PADS-1:0] gpioSel, dirBits, doutBits, penBits, pselBits;

  pinmux_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWr(busWr), .strobe(strobe)
  );

  pinmux_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_HAS_EN(BANK_HAS_EN)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .padIn(padIn),
    .busRdata(busRdata), .gpioSel(gpioSel), .dirBits(dirBits), .doutBits(doutBits),
    .penBits(penBits), .pselBits(pselBits)
  );

  pinmux_padmux #(.PADS(PADS)) uPad (
    .gpioSel(gpioSel), .dirBits(dirBits), .doutBits(doutBits), .penBits(penBits),
    .pselBits(pselBits), .altOut(altOut), .altOe(altOe), .padOut(padOut),
    .padOe(padOe), .padPullUp(padPullUp), .padPullDn(padPullDn)
  );

  // R4: a GPIO pad set to input never drives
  for (genvar p = 0; p < PADS; p++) begin : gChk
    assert_input_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
      (gpioSel[p] && !dirBits[p]) |-> !padOe[p]);
  end
endmodule

// File: tb/tb_gpio_pinmux_top.sv
`timescale 1ns/1ps
module tb_gpio_pinmux_top;
  localparam int NB = 2;
  localparam logic [NB-1:0] HAS_EN = 2'b01;
  localparam int PADS = NB * 32;

  logic clk = 0, rstN = 0;
  logic [3:0] busAddr = '0;
  logic busWr = 0;
  logic [31:0] busWdata = '0, busRdata;
  logic [PADS-1:0] padIn = '0, padOut, padOe, padPullUp, padPullDn;
  logic [PADS-1:0] altOut = '0, altOe = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] mFsel [NB];
  logic [31:0] mDir [NB];
  logic [31:0] mDout [NB];
  logic [31:0] mPen [NB];
  logic [31:0] mPsel [NB];

  always #4 clk = ~clk;

  gpio_pinmux_top #(.NUM_BANKS(NB), .BANK_HAS_EN(HAS_EN)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDn(padPullDn), .altOut(altOut), .altOe(altOe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int idx, input logic [31:0] d);
    @(negedge clk);
    busAddr = 4'(bank * 8 + idx); busWr = 1; busWdata = d;
    @(negedge clk);
    busWr = 0;
    case (idx)
      0: if (HAS_EN[bank]) mFsel[bank] = d;
      1: mDir[bank] = d;
      2: mDout[bank] = d;
      4: mPen[bank] = d;
      5: mPsel[bank] = d;
      default: ;
    endcase
  endtask

  task automatic rd(input int bank, input int idx, output logic [31:0] d);
    @(negedge clk);
    busAddr = 4'(bank * 8 + idx); busWr = 0;
    @(negedge clk);
    d = busRdata;
  endtask

  function automatic logic [31:0] expRead(input int bank, input int idx);
    case (idx)
      0: return HAS_EN[bank] ? mFsel[bank] : 32'h0;
      1: return mDir[bank];
      2: return mDout[bank];
      3: return padIn[bank*32 +: 32];
      4: return mPen[bank];
      5: return mPsel[bank];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [PADS-1:0] gpioOf();
    logic [PADS-1:0] g;
    for (int b = 0; b < NB; b++) g[b*32 +: 32] = HAS_EN[b] ? mFsel[b] : 32'hFFFF_FFFF;
    return g;
  endfunction

  function automatic logic [PADS-1:0] flat(input int which);
    logic [PADS-1:0] v;
    for (int b = 0; b < NB; b++)
      case (which)
        1: v[b*32 +: 32] = mDir[b];
        2: v[b*32 +: 32] = mDout[b];
        4: v[b*32 +: 32] = mPen[b];
        default: v[b*32 +: 32] = mPsel[b];
      endcase
    return v;
  endfunction

  task automatic chkPads(input string tag);
    logic [PADS-1:0] g;
    g = gpioOf();
    chk({tag, " R3 padOe"}, 64'(padOe), 64'((g & flat(1)) | (~g & altOe)));
    chk({tag, " R3 padOut"}, 64'(padOut), 64'((g & flat(2)) | (~g & altOut)));
    chk({tag, " R5 pullUp"}, 64'(padPullUp), 64'(flat(4) & flat(5)));
    chk({tag, " R5 pullDn"}, 64'(padPullDn), 64'(flat(4) & ~flat(5)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin
      mFsel[b] = HAS_EN[b] ? 32'hFFFF_FFFF : 32'h0;
      mDir[b] = 0; mDout[b] = 0; mPen[b] = 0; mPsel[b] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R2 reset state
    chk("R2 padOe", 64'(padOe), 64'h0);
    chk("R2 padOut", 64'(padOut), 64'h0);
    chk("R2 pulls", 64'(padPullUp | padPullDn), 64'h0);
    rd(0, 0, d); chk("R2 fsel bank0", 64'(d), 64'hFFFF_FFFF);
    rd(1, 0, d); chk("R6 fsel fixed bank", 64'(d), 64'h0);

    // R4 / R3 direction split
    wr(0, 1, 32'h0000_FFFF);
    chk("R4 dir half", 64'(padOe), 64'h0000_0000_0000_FFFF);

    // R8 preload while input
    wr(1, 2, 32'hA5A5_5A5A);
    chk("R8 input holds off", 64'(padOe[63:32]), 64'h0);
    wr(1, 1, 32'hFFFF_FFFF);
    chk("R8 preload driven", 64'(padOut[63:32]), 64'hA5A5_5A5A);
    chk("R8 oe on", 64'(padOe[63:32]), 64'hFFFF_FFFF);

    // R6 fixed bank ignores alt and fsel writes
    altOe = '1; altOut = '0;
    wr(1, 0, 32'h0);
    rd(1, 0, d); chk("R6 fsel write ignored", 64'(d), 64'h0);
    chk("R6 still gpio", 64'(padOut[63:32]), 64'hA5A5_5A5A);

    // R3 alternate function on bank0
    altOut = 64'h1234_5678_9ABC_DEF0; altOe = 64'h0F0F_0F0F_F0F0_F0F0;
    wr(0, 0, 32'h0);
    chk("R3 alt out", 64'(padOut[31:0]), 64'h9ABC_DEF0);
    chk("R3 alt oe", 64'(padOe[31:0]), 64'hF0F0_F0F0);
    wr(0, 0, 32'hFFFF_FFFF);

    // R5 bias decode
    wr(0, 4, 32'h0000_00F0);
    wr(0, 5, 32'h0000_00CC);
    chk("R5 up", 64'(padPullUp[31:0]), 64'h0000_00C0);
    chk("R5 dn", 64'(padPullDn[31:0]), 64'h0000_0030);

    // R7 synchroniser lag
    @(negedge clk); padIn = 64'hDEAD_BEEF_0BAD_F00D;
    repeat (3) @(negedge clk);
    padIn = 64'h1111_2222_3333_4444;
    rd(0, 3, d); chk("R7 lag old", 64'(d), 64'h0BAD_F00D);
    @(negedge clk);
    rd(0, 3, d); chk("R7 new level", 64'(d), 64'h3333_4444);
    rd(1, 3, d); chk("R7 bank1 level", 64'(d), 64'h1111_2222);

    // R9 din write ignored, unmapped index
    wr(0, 3, 32'hFFFF_FFFF);
    rd(0, 2, d); chk("R9 dout untouched", 64'(d), 64'(mDout[0]));
    rd(0, 1, d); chk("R9 dir untouched", 64'(d), 64'(mDir[0]));
    rd(0, 6, d); chk("R9 idx6", 64'(d), 64'h0);
    rd(1, 7, d); chk("R9 idx7", 64'(d), 64'h0);

    // random mix, R1 readback
    for (int i = 0; i < 150; i++) begin
      int b, x;
      @(negedge clk);
      altOut = {$urandom, $urandom}; altOe = {$urandom, $urandom};
      padIn = {$urandom, $urandom};
      b = $urandom % NB; x = $urandom % 8;
      wr(b, x, $urandom);
      chkPads("rand");
      b = $urandom % NB; x = $urandom % 8;
      rd(b, x, d); chk("R1 readback", 64'(d), 64'(expRead(b, x)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule